// File: doc/BRIEF.md
# Strap-Driven Boot Source Sequencer

This block chooses where a chip loads its first image from. On the first clock after reset it reads three strap pins and a recovery-plug request. The straps pick one of eight fixed source orders. The sequencer then tries each source in that order through a request/done/ok handshake with external loader stubs. It moves to the next source whenever a loader reports done without ok. It stops either on the first successful load or after the list runs out.

A recovery plug can put a USB-device or SD-card attempt ahead of the strap order. The strap order still runs in full if that forced attempt fails. A forced USB-first attempt is remembered in a flag that only the cold reset clears, so a warm reset repeats the USB-first attempt. The eMMC source is tried in three sub-areas before the sequencer moves on. Each request carries the start sector of the image for the sources that use one.

Top module: `boot_seq_ctrl`

## Requirements
- R1: The strap code is {strap_i[2], strap_i[1], strap_i[0]}, where strap_i[2] is the first strap. The source IDs are USB=0, SPI NOR=1, NAND/eMMC=2, SD=3 and SPI NAND=4. The attempt orders are: 000 and 100 give 0,1,2,3. 001 and 101 give 0,2,3. 010 and 110 give 1,2,3,0. 011 gives 4,2,0. 111 gives 2,3,0.
- R2: The sequencer advances to the next attempt only when ld_done_i is high and ld_ok_i is low. When ld_done_i is high and ld_ok_i is high, boot_ok_o rises, stays high and no further request is made.
- R3: Source 2 is tried in area 0 (user), then area 1 (first boot area), then area 2 (second boot area), and only after that is the next source tried. All other sources use area 0.
- R4: ld_sector_o is 1 for sources 1, 2 and 3, and 0 for sources 0 and 4.
- R5: If plug_vld_i is high when the straps are sampled, one attempt is made first in area 0 on USB (plug_sd_i=0) or SD (plug_sd_i=1). The full strap order follows.
- R6: A plug-forced USB attempt sets a flag that survives warm_rst_n. While the flag is set, every start begins with a forced USB attempt. Only cold_rst_n clears the flag.
- R7: After the last attempt in the order fails, boot_fail_o rises and stays high, and no request is made until the next reset.
- R8: The straps and the plug inputs are sampled once, on the first clock after reset is released. Changes after that do not alter the attempt sequence.
- R9: ld_req_o stays high, with ld_src_o and ld_area_o stable, until ld_done_i arrives. ld_req_o is low for at least one cycle between attempts.
- R10: While either reset is low, ld_req_o, boot_ok_o and boot_fail_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Power-on reset, active low; clears everything including the USB-first flag |
| warm_rst_n | input | 1 | Warm reset, active low; keeps the USB-first flag |
| strap_i | input | 3 | Boot strap pins; bit 2 is the first strap |
| plug_vld_i | input | 1 | Recovery plug requests a forced first attempt |
| plug_sd_i | input | 1 | Forced source: 0 = USB device, 1 = SD card |
| ld_req_o | output | 1 | Load request to the selected loader |
| ld_src_o | output | 3 | Selected source ID |
| ld_area_o | output | AREA_W | Sub-area of the source (eMMC area) |
| ld_sector_o | output | SECT_W | Image start sector |
| ld_done_i | input | 1 | Loader finished the attempt |
| ld_ok_i | input | 1 | Image loaded and checked, valid with ld_done_i |
| boot_ok_o | output | 1 | A source delivered a good image |
| boot_fail_o | output | 1 | Every source in the order failed |

## Verification
The bench walks all eight strap codes. For each one it records every attempt's source, area and sector, and compares the list with the order worked out from the requirement table. A wrong table entry or a skipped eMMC area therefore shows up as a mismatched or missing attempt. Success is placed on first, middle and last entries, so a sequencer that ignores ld_ok_i, or keeps going after success, produces extra attempts. The USB-first flag is exercised over a warm reset and then a cold reset: a flag that resets too easily drops the forced USB attempt, and one that never clears adds a USB attempt where none belongs. Straps and plug inputs are changed in the middle of a run to catch a design that re-reads them.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   localparam int SRC_W = 3;

   typedef enum logic [SRC_W-1:0] {
      SRC_USB   = 3'd0,
      SRC_NOR   = 3'd1,
      SRC_EMMC  = 3'd2,
      SRC_SD    = 3'd3,
      SRC_SNAND = 3'd4
   } src_e;

   typedef enum logic [2:0] {
      ST_SAMPLE = 3'd0,
      ST_REQ    = 3'd1,
      ST_GAP    = 3'd2,
      ST_OK     = 3'd3,
      ST_FAIL   = 3'd4
   } st_e;

   // true for sources whose image begins at a fixed sector
   function automatic logic uses_sector(src_e s);
      return (s == SRC_NOR) || (s == SRC_EMMC) || (s == SRC_SD);
   endfunction

endpackage

// File: rtl/boot_order_lut.sv
module boot_order_lut
   import boot_seq_pkg::*;
#(
   parameter int ORDER_MAX = 4,
   localparam int IDX_W    = (ORDER_MAX > 1) ? $clog2(ORDER_MAX) : 1
) (
   input  logic [2:0]       code_i,
   input  logic [IDX_W-1:0] idx_i,
   output src_e             src_o,
   output logic [IDX_W:0]   len_o
);

   generate
      if (ORDER_MAX < 4) begin : g_bad_depth
         $error("boot_order_lut: ORDER_MAX must hold the longest order (4)");
      end
   endgenerate

   src_e list [ORDER_MAX];

   always_comb begin
      for (int i = 0; i < ORDER_MAX; i++) list[i] = SRC_USB;
      len_o = '0;
      unique case (code_i)
         3'b000, 3'b100: begin
            list[0] = SRC_USB;  list[1] = SRC_NOR;
            list[2] = SRC_EMMC; list[3] = SRC_SD;
            len_o   = (IDX_W+1)'(4);
         end
         3'b001, 3'b101: begin
            list[0] = SRC_USB;  list[1] = SRC_EMMC; list[2] = SRC_SD;
            len_o   = (IDX_W+1)'(3);
         end
         3'b010, 3'b110: begin
            list[0] = SRC_NOR;  list[1] = SRC_EMMC;
            list[2] = SRC_SD;   list[3] = SRC_USB;
            len_o   = (IDX_W+1)'(4);
         end
         3'b011: begin
            list[0] = SRC_SNAND; list[1] = SRC_EMMC; list[2] = SRC_USB;
            len_o   = (IDX_W+1)'(3);
         end
         default: begin
            list[0] = SRC_EMMC; list[1] = SRC_SD; list[2] = SRC_USB;
            len_o   = (IDX_W+1)'(3);
         end
      endcase
   end

   assign src_o = list[idx_i];

endmodule

// File: rtl/boot_usb_latch.sv
module boot_usb_latch #(
   parameter bit KEEP_EN = 1'b1
) (
   input  logic clk,
   input  logic cold_rst_n,
   input  logic set_i,
   output logic q_o
);

   generate
      if (KEEP_EN) begin : g_keep
         logic flag_q;
         always_ff @(posedge clk or negedge cold_rst_n) begin
            if (!cold_rst_n)  flag_q <= 1'b0;
            else if (set_i)   flag_q <= 1'b1;
         end
         assign q_o = flag_q;

         AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!cold_rst_n)
            q_o |=> q_o); // R6
         AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!cold_rst_n)
            set_i |=> q_o); // R6
      end else begin : g_drop
         logic unused_set;
         assign unused_set = set_i;
         assign q_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
   import boot_seq_pkg::*;
#(
   parameter int AREA_W     = 2,
   parameter int SECT_W     = 16,
   parameter int IMG_SECTOR = 1,
   parameter int EMMC_AREAS = 3,
   parameter int ORDER_MAX  = 4,
   localparam int IDX_W     = (ORDER_MAX > 1) ? $clog2(ORDER_MAX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        strap_i,
   input  logic              plug_vld_i,
   input  logic              plug_sd_i,
   input  logic              sticky_i,
   output logic              sticky_set_o,
   output logic [2:0]        code_o,
   output logic [IDX_W-1:0]  idx_o,
   input  src_e              lut_src_i,
   input  logic [IDX_W:0]    lut_len_i,
   output logic              ld_req_o,
   output src_e              ld_src_o,
   output logic [AREA_W-1:0] ld_area_o,
   output logic [SECT_W-1:0] ld_sector_o,
   input  logic              ld_done_i,
   input  logic              ld_ok_i,
   output logic              boot_ok_o,
   output logic              boot_fail_o
);

   localparam logic [AREA_W-1:0] AREA_LAST = AREA_W'(EMMC_AREAS - 1);

   generate
      if (EMMC_AREAS < 1 || EMMC_AREAS > (1 << AREA_W)) begin : g_bad_area
         $error("boot_seq_fsm: EMMC_AREAS does not fit AREA_W");
      end
      if (IMG_SECTOR >= (1 << SECT_W)) begin : g_bad_sector
         $error("boot_seq_fsm: IMG_SECTOR does not fit SECT_W");
      end
   endgenerate

   st_e               st_q;
   logic [2:0]        code_q;
   logic              forced_q;
   src_e              forced_src_q;
   logic [IDX_W-1:0]  idx_q;
   logic [AREA_W-1:0] area_q;
   src_e              cur_src;
   logic              want_usb;
   logic              list_end;

   assign want_usb = (plug_vld_i && !plug_sd_i) || sticky_i;
   assign cur_src  = forced_q ? forced_src_q : lut_src_i;
   assign list_end = ({1'b0, idx_q} == (lut_len_i - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_SAMPLE;
         code_q       <= '0;
         forced_q     <= 1'b0;
         forced_src_q <= SRC_USB;
         idx_q        <= '0;
         area_q       <= '0;
      end else begin
         unique case (st_q)
            ST_SAMPLE: begin
               code_q <= strap_i;
               idx_q  <= '0;
               area_q <= '0;
               if (want_usb) begin
                  forced_q     <= 1'b1;
                  forced_src_q <= SRC_USB;
               end else if (plug_vld_i) begin
                  forced_q     <= 1'b1;
                  forced_src_q <= SRC_SD;
               end
               st_q <= ST_REQ;
            end
            ST_REQ: begin
               if (ld_done_i) begin
                  if (ld_ok_i) begin
                     st_q <= ST_OK;
                  end else if (cur_src == SRC_EMMC && area_q != AREA_LAST) begin
                     area_q <= area_q + 1'b1;
                     st_q   <= ST_GAP;
                  end else begin
                     area_q <= '0;
                     if (forced_q) begin
                        forced_q <= 1'b0;
                        st_q     <= ST_GAP;
                     end else if (list_end) begin
                        st_q <= ST_FAIL;
                     end else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= ST_GAP;
                     end
                  end
               end
            end
            ST_GAP:  st_q <= ST_REQ;
            ST_OK:   st_q <= ST_OK;
            default: st_q <= ST_FAIL;
         endcase
      end
   end

   assign sticky_set_o = (st_q == ST_SAMPLE) && plug_vld_i && !plug_sd_i;
   assign code_o       = code_q;
   assign idx_o        = idx_q;
   assign ld_req_o     = (st_q == ST_REQ);
   assign ld_src_o     = cur_src;
   assign ld_area_o    = area_q;
   assign ld_sector_o  = uses_sector(cur_src) ? SECT_W'(IMG_SECTOR) : '0;
   assign boot_ok_o    = (st_q == ST_OK);
   assign boot_fail_o  = (st_q == ST_FAIL);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req_o && !ld_done_i |=> ld_req_o && $stable(ld_src_o) && $stable(ld_area_o)); // R9
   AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req_o && ld_done_i |=> !ld_req_o); // R9
   AST_OK_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      boot_ok_o |=> boot_ok_o && !ld_req_o && !boot_fail_o); // R2
   AST_FAIL_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      boot_fail_o |=> boot_fail_o && !ld_req_o && !boot_ok_o); // R7
   AST_AREA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req_o && ld_src_o != SRC_EMMC |-> ld_area_o == '0); // R3
   AST_AREA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req_o && ld_done_i && !ld_ok_i && ld_src_o == SRC_EMMC && ld_area_o != AREA_LAST
      |=> ld_area_o == $past(ld_area_o) + 1'b1); // R3
   AST_SECTOR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req_o && (ld_src_o == SRC_SD || ld_src_o == SRC_EMMC || ld_src_o == SRC_NOR)
      |-> ld_sector_o == SECT_W'(IMG_SECTOR)); // R4
   AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      st_q != ST_SAMPLE |=> $stable(code_o)); // R8
   AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ld_req_o, boot_ok_o, boot_fail_o})); // R2

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
   import boot_seq_pkg::*;
#(
   parameter int AREA_W     = 2,
   parameter int SECT_W     = 16,
   parameter int IMG_SECTOR = 1,
   parameter int EMMC_AREAS = 3,
   parameter int ORDER_MAX  = 4,
   parameter bit KEEP_USB   = 1'b1
) (
   input  logic              clk,
   input  logic              cold_rst_n,
   input  logic              warm_rst_n,
   input  logic [2:0]        strap_i,
   input  logic              plug_vld_i,
   input  logic              plug_sd_i,
   output logic              ld_req_o,
   output logic [SRC_W-1:0]  ld_src_o,
   output logic [AREA_W-1:0] ld_area_o,
   output logic [SECT_W-1:0] ld_sector_o,
   input  logic              ld_done_i,
   input  logic              ld_ok_i,
   output logic              boot_ok_o,
   output logic              boot_fail_o
);

   localparam int IDX_W = (ORDER_MAX > 1) ? $clog2(ORDER_MAX) : 1;

   logic             sys_rst_n;
   logic             sticky;
   logic             sticky_set;
   logic [2:0]       code;
   logic [IDX_W-1:0] idx;
   src_e             lut_src;
   logic [IDX_W:0]   lut_len;
   src_e             src_sel;

   assign sys_rst_n = cold_rst_n & warm_rst_n;

   boot_usb_latch #(.KEEP_EN(KEEP_USB)) u_latch (
      .clk        (clk),
      .cold_rst_n (cold_rst_n),
      .set_i      (sticky_set),
      .q_o        (sticky)
   );

   boot_order_lut #(.ORDER_MAX(ORDER_MAX)) u_lut (
      .code_i (code),
      .idx_i  (idx),
      .src_o  (lut_src),
      .len_o  (lut_len)
   );

   boot_seq_fsm #(
      .AREA_W     (AREA_W),
      .SECT_W     (SECT_W),
      .IMG_SECTOR (IMG_SECTOR),
      .EMMC_AREAS (EMMC_AREAS),
      .ORDER_MAX  (ORDER_MAX)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (sys_rst_n),
      .strap_i      (strap_i),
      .plug_vld_i   (plug_vld_i),
      .plug_sd_i    (plug_sd_i),
      .sticky_i     (sticky),
      .sticky_set_o (sticky_set),
      .code_o       (code),
      .idx_o        (idx),
      .lut_src_i    (lut_src),
      .lut_len_i    (lut_len),
      .ld_req_o     (ld_req_o),
      .ld_src_o     (src_sel),
      .ld_area_o    (ld_area_o),
      .ld_sector_o  (ld_sector_o),
      .ld_done_i    (ld_done_i),
      .ld_ok_i      (ld_ok_i),
      .boot_ok_o    (boot_ok_o),
      .boot_fail_o  (boot_fail_o)
   );

   assign ld_src_o = src_sel;

   AST_QUIET_IN_RESET: assert property (@(posedge clk)
      !sys_rst_n |-> !ld_req_o && !boot_ok_o && !boot_fail_o); // R10

endmodule

// File: tb/boot_seq_ctrl_test.sv
`timescale 1ns/1ps
module boot_seq_ctrl_test;

   logic       clk = 1'b0;
   logic       cold_rst_n = 1'b0;
   logic       warm_rst_n = 1'b0;
   logic [2:0] strap_i = 3'b111;
   logic       plug_vld_i = 1'b0;
   logic       plug_sd_i = 1'b0;
   logic       ld_req_o;
   logic [2:0] ld_src_o;
   logic [1:0] ld_area_o;
   logic [15:0] ld_sector_o;
   logic       ld_done_i = 1'b0;
   logic       ld_ok_i = 1'b0;
   logic       boot_ok_o;
   logic       boot_fail_o;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   boot_seq_ctrl uut (
      .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
      .strap_i(strap_i), .plug_vld_i(plug_vld_i), .plug_sd_i(plug_sd_i),
      .ld_req_o(ld_req_o), .ld_src_o(ld_src_o), .ld_area_o(ld_area_o),
      .ld_sector_o(ld_sector_o), .ld_done_i(ld_done_i), .ld_ok_i(ld_ok_i),
      .boot_ok_o(boot_ok_o), .boot_fail_o(boot_fail_o)
   );

   // loader stub: answers each request two cycles later, records the attempt
   logic [2:0] succ_src = 3'd7;
   logic [1:0] succ_area = 2'd0;
   int         rec_n = 0;
   logic [2:0] rec_src  [16];
   logic [1:0] rec_area [16];
   logic [15:0] rec_sec [16];

   initial forever begin
      @(negedge clk);
      if (ld_req_o) begin
         repeat (2) @(negedge clk);
         if (rec_n < 16) begin
            rec_src[rec_n]  = ld_src_o;
            rec_area[rec_n] = ld_area_o;
            rec_sec[rec_n]  = ld_sector_o;
         end
         rec_n++;
         ld_ok_i   = (ld_src_o == succ_src) && (ld_area_o == succ_area);
         ld_done_i = 1'b1;
         @(negedge clk);
         ld_done_i = 1'b0;
         ld_ok_i   = 1'b0;
      end
   end

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // expected attempt list built from the requirement table
   int         exp_n;
   bit         exp_hit;
   logic [2:0] exp_src  [16];
   logic [1:0] exp_area [16];

   task automatic push(input logic [2:0] s, input logic [1:0] a);
      if (!exp_hit && exp_n < 16) begin
         exp_src[exp_n]  = s;
         exp_area[exp_n] = a;
         exp_n++;
         if (s == succ_src && a == succ_area) exp_hit = 1'b1;
      end
   endtask

   task automatic build_exp(input logic [2:0] code, input bit fv, input logic [2:0] fsrc);
      logic [2:0] ord [4];
      int n;
      case (code)  // R1 order table
         3'b000, 3'b100: begin ord = '{3'd0, 3'd1, 3'd2, 3'd3}; n = 4; end
         3'b001, 3'b101: begin ord = '{3'd0, 3'd2, 3'd3, 3'd0}; n = 3; end
         3'b010, 3'b110: begin ord = '{3'd1, 3'd2, 3'd3, 3'd0}; n = 4; end
         3'b011:         begin ord = '{3'd4, 3'd2, 3'd0, 3'd0}; n = 3; end
         default:        begin ord = '{3'd2, 3'd3, 3'd0, 3'd0}; n = 3; end
      endcase
      exp_n = 0;
      exp_hit = 1'b0;
      if (fv) push(fsrc, 2'd0);
      for (int i = 0; i < n; i++) begin
         if (ord[i] == 3'd2) begin
            for (int a = 0; a < 3; a++) push(3'd2, 2'(a));
         end else begin
            push(ord[i], 2'd0);
         end
      end
   endtask

   task automatic do_reset(input bit cold);
      @(negedge clk);
      warm_rst_n = 1'b0;
      if (cold) cold_rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!ld_req_o && !boot_ok_o && !boot_fail_o, "R10 quiet in reset",
          {ld_req_o, boot_ok_o, boot_fail_o}, 0);
      rec_n = 0;
      cold_rst_n = 1'b1;
      warm_rst_n = 1'b1;
   endtask

   task automatic run_case(input bit cold, input logic [2:0] code, input bit pv, input bit psd,
                           input bit efv, input logic [2:0] efs,
                           input logic [2:0] ssrc, input logic [1:0] sarea,
                           input bit perturb, input string tag);
      int wait_n;
      strap_i    = code;
      plug_vld_i = pv;
      plug_sd_i  = psd;
      succ_src   = ssrc;
      succ_area  = sarea;
      do_reset(cold);
      build_exp(code, efv, efs);
      if (perturb) begin
         repeat (2) @(negedge clk);
         strap_i    = ~code;   // R8 late change must be ignored
         plug_vld_i = 1'b1;
         plug_sd_i  = 1'b1;
      end
      wait_n = 0;
      while (!(boot_ok_o || boot_fail_o) && wait_n < 3000) begin
         @(negedge clk);
         wait_n++;
      end
      chk(wait_n < 3000, {tag, " finished"}, wait_n, 3000);
      chk(rec_n == exp_n, {tag, " attempt count"}, rec_n, exp_n);
      for (int i = 0; i < exp_n && i < rec_n; i++) begin
         chk(rec_src[i] == exp_src[i], {tag, " R1 source"}, rec_src[i], exp_src[i]);
         chk(rec_area[i] == exp_area[i], {tag, " R3 area"}, rec_area[i], exp_area[i]);
         chk(rec_sec[i] == ((rec_src[i] inside {3'd1, 3'd2, 3'd3}) ? 16'd1 : 16'd0),
             {tag, " R4 sector"}, rec_sec[i], (rec_src[i] inside {3'd1, 3'd2, 3'd3}) ? 1 : 0);
      end
      chk(boot_ok_o == exp_hit, {tag, " R2 ok flag"}, boot_ok_o, exp_hit);
      chk(boot_fail_o == !exp_hit, {tag, " R7 fail flag"}, boot_fail_o, !exp_hit);
      repeat (4) @(negedge clk);
      chk(!ld_req_o && (boot_ok_o == exp_hit) && (boot_fail_o == !exp_hit),
          {tag, " R7 R2 idle after end"}, {ld_req_o, boot_ok_o, boot_fail_o},
          {1'b0, exp_hit, !exp_hit});
      strap_i    = code;
      plug_vld_i = 1'b0;
      plug_sd_i  = 1'b0;
   endtask

   // fields: code[9:7] plug_vld[6] plug_sd[5] succ_src[4:2] succ_area[1:0]; succ_src 7 = none
   localparam logic [9:0] VEC [11] = '{
      10'b111_0_0_111_00,
      10'b111_0_0_010_10,
      10'b000_0_0_011_00,
      10'b001_0_0_111_00,
      10'b010_0_0_000_00,
      10'b011_0_0_100_00,
      10'b100_0_0_111_00,
      10'b101_0_0_011_00,
      10'b110_0_0_111_00,
      10'b111_1_1_111_00,
      10'b011_1_1_010_01
   };

   initial begin
      #1_000_000;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      // table walk: R1 R2 R3 R4 R5 R7
      for (int v = 0; v < 11; v++) begin
         run_case(1'b1, VEC[v][9:7], VEC[v][6], VEC[v][5], VEC[v][6],
                  VEC[v][5] ? 3'd3 : 3'd0, VEC[v][4:2], VEC[v][1:0], 1'b0,
                  $sformatf("vec%0d", v));
      end
      // R8: straps and plug changed after sampling
      run_case(1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 3'd0, 3'd7, 2'd0, 1'b1, "R8 late straps");
      // R6: forced USB, then warm reset keeps it, cold reset clears it
      run_case(1'b1, 3'b101, 1'b1, 1'b0, 1'b1, 3'd0, 3'd7, 2'd0, 1'b0, "R6 plug usb");
      run_case(1'b0, 3'b111, 1'b0, 1'b0, 1'b1, 3'd0, 3'd7, 2'd0, 1'b0, "R6 warm keeps");
      run_case(1'b0, 3'b111, 1'b0, 1'b0, 1'b1, 3'd0, 3'd3, 2'd0, 1'b0, "R6 warm again");
      run_case(1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 3'd0, 3'd7, 2'd0, 1'b0, "R6 cold clears");
      // R5 with success on the forced SD attempt itself
      run_case(1'b1, 3'b010, 1'b1, 1'b1, 1'b1, 3'd3, 3'd3, 2'd0, 1'b0, "R5 forced sd ok");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule